// File: doc/BRIEF.md
# Spawn Controller and Thread-ID Dispatcher

This block switches a processor built from several thread units between a serial mode and a parallel mode. In serial mode only unit 0 runs. A spawn command carries a count `n` of virtual threads. Once no global writes are outstanding, the controller starts the parallel phase. Every unit whose index is below `n` receives its own index as its first thread ID. Every other unit is marked as already finished.

During the parallel phase a unit that completes a thread raises a one-cycle request. On the next clock edge the controller answers from an internal fetch-and-increment counter. The counter starts at the number of units. If the value is below `n`, the unit receives a grant carrying that ID. Otherwise the unit is marked joined and goes inactive. No unit waits for any other unit between waves of threads. When every unit is joined, the controller raises `join_wait`. It returns to serial mode only after `wr_pending` is low.

Top module: `spawn_dispatch`

## Requirements
- R1: After reset, and whenever the block is in serial mode, `serial_mode` is 1, `unit_active` equals 1 (only unit 0 active), `join_wait` is 0 and no grant is issued.
- R2: On the clock edge that accepts a spawn of `n`, each unit `i` with `i < n` gets a one-cycle grant with ID `i`. Units with `i >= n` get no grant and are inactive.
- R3: Over one parallel phase, every ID from 0 to `n-1` is granted exactly once, and no ID of `n` or more is ever granted.
- R4: Requests made in the same cycle are answered on the next edge with consecutive IDs, which increase with unit index.
- R5: A request whose ID would be `n` or more gets no grant. From the next edge on, that unit's `unit_active` bit is 0.
- R6: Once every unit is joined, `join_wait` goes to 1. `serial_mode` stays 0 for as long as `wr_pending` is 1.
- R7: In the drain state, the first clock edge that sees `wr_pending` at 0 returns the block to serial mode. At that point `join_wait` is 0 and `unit_active` is 1.
- R8: A spawn that arrives while `wr_pending` is 1 is held in serial mode with no grants. It launches on the first edge that sees `wr_pending` at 0.
- R9: `spawn_req` has no effect outside serial mode. A spawn issued during a parallel phase changes neither the granted IDs nor the count in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Spawn command strobe |
| spawn_count | input | IDW | Number of virtual threads `n` |
| wr_pending | input | 1 | High while global writes have not yet been broadcast |
| unit_req | input | NU | Per-unit request for a fresh thread ID, one cycle per finished thread |
| unit_active | output | NU | Per-unit active flag |
| grant_vld | output | NU | Per-unit one-cycle ID grant strobe |
| grant_id | output | NU*IDW | Per-unit granted ID; unit `i` uses bits `i*IDW +: IDW` |
| serial_mode | output | 1 | High in serial mode, including a held spawn |
| join_wait | output | 1 | High after all units have joined, until the writes drain |

## Verification
The dispatcher is driven by behavioural unit models. One setting gives every unit the same latency, so all units request in the same cycle. This exposes the rank-ordered consecutive IDs and any duplicated or skipped counter value. Another setting gives staggered, ID-dependent latencies. This shows that IDs are handed out as units free up, with no barrier between waves. The thread counts cover zero, one, fewer than the unit count, exactly the unit count, one more than it, and many times it; these cover the launch-only case and the point where joining starts. A spawn held back by pending writes and a spawn issued mid-phase check the deferred-launch and ignore paths.

// File: rtl/spawn_dispatch.sv
module spawn_dispatch #(
  parameter int NU  = 4,
  parameter int IDW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spawn_req,
  input  logic [IDW-1:0]  spawn_count,
  input  logic            wr_pending,
  input  logic [NU-1:0]   unit_req,
  output logic [NU-1:0]   unit_active,
  output logic [NU-1:0]   grant_vld,
  output logic [NU*IDW-1:0] grant_id,
  output logic            serial_mode,
  output logic            join_wait
);
  localparam int CW = IDW + 1;

  typedef enum logic [1:0] {S_SER, S_HOLD, S_PAR, S_DRAIN} st_t;

  st_t            st;
  logic [IDW-1:0] n_q;
  logic [CW-1:0]  ctr;
  logic [NU-1:0]  joined;
  logic [CW-1:0]  cand [NU];
  logic [CW-1:0]  nreq;

  wire            launch = ((st == S_SER && spawn_req) || st == S_HOLD) && !wr_pending;
  wire [IDW-1:0]  n_sel  = (st == S_SER) ? spawn_count : n_q;

  assign serial_mode = (st == S_SER) || (st == S_HOLD);
  assign join_wait   = (st == S_DRAIN);
  assign unit_active = serial_mode ? NU'(1) : ((st == S_PAR) ? ~joined : '0);

  always_comb begin
    nreq = '0;
    for (int i = 0; i < NU; i++) begin
      cand[i] = ctr + nreq;
      if (unit_req[i] && !joined[i]) nreq = nreq + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_SER;
      n_q       <= '0;
      ctr       <= '0;
      joined    <= '0;
      grant_vld <= '0;
      grant_id  <= '0;
    end else begin
      grant_vld <= '0;
      case (st)
        S_SER: if (spawn_req) begin
          n_q <= spawn_count;
          if (wr_pending) st <= S_HOLD;
        end
        S_PAR: begin
          for (int i = 0; i < NU; i++) begin
            if (unit_req[i] && !joined[i]) begin
              if (cand[i] < {1'b0, n_q}) begin
                grant_vld[i]             <= 1'b1;
                grant_id[i*IDW +: IDW]   <= cand[i][IDW-1:0];
              end else begin
                joined[i] <= 1'b1;
              end
            end
          end
          ctr <= ctr + nreq;
          if (&joined) st <= S_DRAIN;
        end
        S_DRAIN: if (!wr_pending) st <= S_SER;
        default: ;
      endcase
      if (launch) begin
        st  <= S_PAR;
        ctr <= CW'(NU);
        for (int i = 0; i < NU; i++) begin
          grant_id[i*IDW +: IDW] <= IDW'(i);
          grant_vld[i]           <= (CW'(i) < {1'b0, n_sel});
          joined[i]              <= !(CW'(i) < {1'b0, n_sel});
        end
      end
    end
  end

  // R1
  serial_one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serial_mode |-> (unit_active == NU'(1) && grant_vld == '0));

  // R7
  resume_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serial_mode) |-> (!$past(wr_pending) && $past(join_wait)));

  // R8
  launch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serial_mode) |-> !$past(wr_pending));

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_wait && wr_pending) |=> !serial_mode);

  generate
    for (genvar g = 0; g < NU; g++) begin : g_unit_chk
      // R3
      id_below_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld[g] |-> (grant_id[g*IDW +: IDW] < n_q));
      // R5
      joined_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PAR && !unit_active[g]) |=> !unit_active[g]);
    end
  endgenerate
endmodule

// File: tb/spawn_dispatch_test.sv
`timescale 1ns/1ps
module spawn_dispatch_test;
  localparam int NU  = 4;
  localparam int IDW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              spawn_req = 1'b0;
  logic [IDW-1:0]    spawn_count = '0;
  logic              wr_pending = 1'b0;
  logic [NU-1:0]     unit_req = '0;
  logic [NU-1:0]     unit_active;
  logic [NU-1:0]     grant_vld;
  logic [NU*IDW-1:0] grant_id;
  logic              serial_mode;
  logic              join_wait;

  spawn_dispatch #(.NU(NU), .IDW(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .spawn_count(spawn_count),
    .wr_pending(wr_pending), .unit_req(unit_req), .unit_active(unit_active),
    .grant_vld(grant_vld), .grant_id(grant_id), .serial_mode(serial_mode),
    .join_wait(join_wait));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // {n[7:0], same_latency, drain_cycles[3:0], pending_at_spawn, poke_mid_phase}
  localparam logic [14:0] VEC [9] = '{
    {8'd0,  1'b0, 4'd2, 1'b0, 1'b0},
    {8'd1,  1'b0, 4'd0, 1'b0, 1'b0},
    {8'd3,  1'b1, 4'd1, 1'b0, 1'b0},
    {8'd4,  1'b1, 4'd3, 1'b0, 1'b0},
    {8'd5,  1'b1, 4'd0, 1'b0, 1'b0},
    {8'd13, 1'b0, 4'd2, 1'b0, 1'b0},
    {8'd30, 1'b0, 4'd1, 1'b0, 1'b1},
    {8'd9,  1'b0, 4'd0, 1'b1, 1'b0},
    {8'd20, 1'b1, 4'd5, 1'b0, 1'b0}
  };

  int seen [64];
  int extra = 0;
  int order_bad = 0;
  int n_cur = 0;
  bit same_lat = 1'b0;
  bit running [NU];
  bit pend [NU];
  int timer [NU];
  int id;
  int prev_id;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NU; i++) begin
      running[i] = 1'b0; pend[i] = 1'b0; timer[i] = 0;
    end
  end

  // behavioural thread units
  always @(negedge clk) if (rst_n) begin
    prev_id = -1;
    for (int i = 0; i < NU; i++) begin
      unit_req[i] = 1'b0;
      if (grant_vld[i]) begin
        id = int'(grant_id[i*IDW +: IDW]);
        if (id < n_cur && id < 64) seen[id]++;
        else extra++;
        if (prev_id >= 0 && id != prev_id + 1) order_bad++;
        prev_id = id;
        running[i] = 1'b1;
        pend[i] = 1'b0;
        timer[i] = same_lat ? 2 : ((i * 3 + id) % 4) + 1;
      end else begin
        if (pend[i]) begin
          chk(!unit_active[i], "R5", unit_active[i], 0);
          pend[i] = 1'b0;
        end
        if (running[i]) begin
          if (timer[i] == 0) begin
            unit_req[i] = 1'b1;
            running[i] = 1'b0;
            pend[i] = 1'b1;
          end else timer[i]--;
        end
      end
    end
  end

  task automatic run_spawn(input logic [7:0] n, input bit same, input logic [3:0] drain,
                           input bit pre, input bit poke);
    logic [NU-1:0] exp_first;
    int miss;
    for (int k = 0; k < 64; k++) seen[k] = 0;
    extra = 0; order_bad = 0; n_cur = int'(n); same_lat = same;
    @(negedge clk);
    if (pre) wr_pending = 1'b1;
    spawn_req = 1'b1; spawn_count = n;
    @(negedge clk);
    spawn_req = 1'b0;
    if (pre) begin
      for (int k = 0; k < 4; k++) begin
        chk(grant_vld == '0 && serial_mode, "R8", int'(grant_vld), 0);
        @(negedge clk);
      end
      wr_pending = 1'b0;
      @(negedge clk);
    end
    exp_first = (n >= NU) ? '1 : NU'((1 << n) - 1);
    chk(grant_vld == exp_first && unit_active == exp_first, "R2", int'(grant_vld), int'(exp_first));
    wr_pending = 1'b1;
    if (poke) begin
      @(negedge clk);
      spawn_req = 1'b1; spawn_count = n + 8'd5;
      @(negedge clk);
      spawn_req = 1'b0;
    end
    while (!join_wait) @(negedge clk);
    chk(!serial_mode && unit_active == '0, "R6", int'(serial_mode), 0);
    for (int k = 0; k < int'(drain); k++) begin
      @(negedge clk);
      chk(!serial_mode && join_wait, "R6", int'(serial_mode), 0);
    end
    wr_pending = 1'b0;
    @(negedge clk);
    chk(serial_mode && !join_wait && unit_active == NU'(1), "R7", int'(unit_active), 1);
    miss = 0;
    for (int k = 0; k < int'(n); k++) if (seen[k] != 1) miss++;
    chk(miss == 0 && extra == 0, "R3", miss + extra, 0);
    chk(order_bad == 0, "R4", order_bad, 0);
    if (poke) chk(extra == 0 && miss == 0, "R9", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(serial_mode && unit_active == NU'(1) && grant_vld == '0 && !join_wait,
        "R1", int'(unit_active), 1);
    for (int v = 0; v < 9; v++)
      run_spawn(VEC[v][14:7], VEC[v][6], VEC[v][5:2], VEC[v][1], VEC[v][0]);
    repeat (3) @(negedge clk);
    chk(serial_mode && grant_vld == '0, "R1", int'(grant_vld), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule